// File: doc/BRIEF.md
# USB dual-role low-power idle and wake controller

This block controls the idle low-power mode of a USB dual-role (On-The-Go) controller. When no session is active, software may ask for power saving. The block first suspends the host and device cores. After a short settling window it turns off the main oscillator and PLL enables and moves the VBUS charge pump into suspend. All of its logic runs on a slow always-on clock, so it keeps watching for wake events while the main clocks are off.

Three line events can wake the chip, and each has its own enable: a change on the ID pin, a change on the B-session-valid line, and a rising edge of session-request detection. Chip select from the host bus always wakes the chip, whatever the enables say. On wake, the oscillator and PLL enables return at once. The cores stay suspended, and the clock-valid indication stays low, until a fixed stabilization window has elapsed.

The block also keeps the nine event status bits. Each bit is cleared by writing a one to it. The status is masked per bit and ORed into a summary flag. That flag reaches the interrupt pin only when both its own enable and the global pin enable are set.

Top module: `otg_pwr_wake`

## Requirements
- R1: A sleep request is accepted only in the active state while `in_session` is low. A request during a session leaves every power output at its active value.
- R2: An accepted request holds the cores suspended, with clocks still enabled and clock-valid high, for ENTER_CYC cycles (4). The block then goes to sleep: oscillator and PLL enables low, charge pump suspended, clock-valid low, cores still suspended.
- R3: With `wake_en[0]` set, a change on `id_pin` wakes the chip. After two synchronizer stages and one history stage, the wake state is seen after the third rising clock edge.
- R4: With `wake_en[1]` set, a change on `bsv_pin` wakes the chip, with the same latency as R3.
- R5: With `wake_en[2]` set, a rising edge on `srp_det` wakes the chip, with the same latency as R3.
- R6: A line event whose enable bit is clear leaves the chip asleep.
- R7: A `bus_cs` pulse wakes the chip from sleep on the next edge, regardless of `wake_en`.
- R8: On wake, the oscillator and PLL enables rise and the charge pump leaves suspend at once. The cores stay suspended and clock-valid stays low for STAB_CYC cycles (16), after which the block is fully active.
- R9: A wake event during the entry window returns the block straight to the active state.
- R10: Status bit 0 is set by an ID change, bit 1 by a B-session-valid change and bit 2 by a session-request rise; any bit is also set by `evt_in`. A write strobe clears the bits that are one in `clr_mask`. A set in the same cycle wins over the clear.
- R11: `otg_irq` is the OR of `otg_stat & irq_ie`. `int_out` is `otg_irq` gated by `otg_irq_en` and then by `pin_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_session | input | 1 | A USB session is in progress |
| sleep_req | input | 1 | Request to enter power saving |
| wake_en | input | 3 | Wake enables: bit0 ID, bit1 B-session-valid, bit2 session request |
| id_pin | input | 1 | ID line, asynchronous |
| bsv_pin | input | 1 | B-session-valid line, asynchronous |
| srp_det | input | 1 | Session-request detection, asynchronous |
| bus_cs | input | 1 | Host bus chip select |
| evt_in | input | 9 | Extra event set strobes per status bit |
| clr_we | input | 1 | Status clear write strobe |
| clr_mask | input | 9 | Write-one-to-clear data |
| irq_ie | input | 9 | Per-bit status interrupt enables |
| otg_irq_en | input | 1 | Summary flag enable |
| pin_en | input | 1 | Global interrupt pin enable |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| cp_suspend | output | 1 | Charge pump suspend |
| dc_suspend | output | 1 | Device core suspend |
| hc_suspend | output | 1 | Host core suspend |
| clk_valid | output | 1 | Core clocks stable and usable |
| otg_stat | output | 9 | Event status bits |
| otg_irq | output | 1 | Summary interrupt flag |
| int_out | output | 1 | Interrupt pin, active high |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a four-cycle entry window and a sixteen-cycle stabilization window. With these values, every phase of the power sequence can be counted edge by edge, and the abort case can be hit inside the short entry window. The sixteen-cycle wake window is walked through in full, so the bench sees clock-valid rise on the exact cycle. The nine-bit status field is exercised by random set, clear and enable patterns, which hit set-versus-clear collisions and every gating combination of the two interrupt enables.

// File: rtl/otg_pw_pkg.sv
package otg_pw_pkg;
    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_ENTER  = 2'd1,
        PS_SLEEP  = 2'd2,
        PS_WAKE   = 2'd3
    } ps_state_e;

    localparam int LN_ID  = 0;
    localparam int LN_BSV = 1;
    localparam int LN_SRP = 2;
    localparam int N_LINES = 3;
endpackage

// File: rtl/otg_line_sync.sv
module otg_line_sync #(
    parameter int STAGES    = 2,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic evt
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              hist;
    } sync_t;

    sync_t r_d, r_q;
    logic  lvl;

    assign lvl = r_q.chain[STAGES-1];

    always_comb begin
        r_d       = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], line_in};
        r_d.hist  = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    generate
        if (RISE_ONLY) begin : g_rise
            assign evt = lvl & ~r_q.hist;
        end else begin : g_any
            assign evt = lvl ^ r_q.hist;
        end
    endgenerate
endmodule

// File: rtl/otg_ps_fsm.sv
module otg_ps_fsm
    import otg_pw_pkg::*;
#(
    parameter int ENTER_CYC = 4,
    parameter int STAB_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_session,
    input  logic sleep_req,
    input  logic wake,
    output logic osc_en,
    output logic pll_en,
    output logic cp_suspend,
    output logic dc_suspend,
    output logic hc_suspend,
    output logic clk_valid
);
    localparam int MAXC = (ENTER_CYC > STAB_CYC) ? ENTER_CYC : STAB_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        ps_state_e     st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            PS_ACTIVE: begin
                if (sleep_req && !in_session) begin
                    f_d.st  = PS_ENTER;
                    f_d.cnt = '0;
                end
            end
            PS_ENTER: begin
                if (wake) begin
                    f_d.st = PS_ACTIVE;
                end else if (f_q.cnt == CW'(ENTER_CYC - 1)) begin
                    f_d.st = PS_SLEEP;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            PS_SLEEP: begin
                if (wake) begin
                    f_d.st  = PS_WAKE;
                    f_d.cnt = '0;
                end
            end
            PS_WAKE: begin
                if (f_q.cnt == CW'(STAB_CYC - 1)) f_d.st = PS_ACTIVE;
                else                              f_d.cnt = f_q.cnt + 1'b1;
            end
            default: f_d.st = PS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: PS_ACTIVE, cnt: '0};
        else        f_q <= f_d;
    end

    always_comb begin
        osc_en     = (f_q.st != PS_SLEEP);
        pll_en     = (f_q.st != PS_SLEEP);
        cp_suspend = (f_q.st == PS_SLEEP);
        dc_suspend = (f_q.st != PS_ACTIVE);
        hc_suspend = (f_q.st != PS_ACTIVE);
        clk_valid  = (f_q.st == PS_ACTIVE) || (f_q.st == PS_ENTER);
    end

    AST_SESSION_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_ACTIVE && in_session) |=> (f_q.st == PS_ACTIVE)); // R1
    AST_ENTRY_STAYS_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_ENTER && !wake && f_q.cnt != CW'(ENTER_CYC - 1)) |=> (f_q.st == PS_ENTER)); // R2
    AST_SLEEP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_SLEEP && wake) |=> (f_q.st == PS_WAKE)); // R7
    AST_STAB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_WAKE && f_q.cnt != CW'(STAB_CYC - 1)) |=> !clk_valid); // R8
    AST_ENTRY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PS_ENTER && wake) |=> (f_q.st == PS_ACTIVE)); // R9
endmodule

// File: rtl/otg_irq_cascade.sv
module otg_irq_cascade #(
    parameter int N_EVT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] set_vec,
    input  logic             clr_we,
    input  logic [N_EVT-1:0] clr_mask,
    input  logic [N_EVT-1:0] irq_ie,
    input  logic             otg_irq_en,
    input  logic             pin_en,
    output logic [N_EVT-1:0] otg_stat,
    output logic             otg_irq,
    output logic             int_out
);
    typedef struct packed {
        logic [N_EVT-1:0] stat;
    } irq_t;

    irq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_we) s_d.stat = s_d.stat & ~clr_mask;
        s_d.stat = s_d.stat | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign otg_stat = s_q.stat;
    assign otg_irq  = |(s_q.stat & irq_ie);
    assign int_out  = otg_irq & otg_irq_en & pin_en;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((otg_stat & $past(clr_mask & ~set_vec)) == '0)); // R10
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((otg_stat & $past(set_vec)) == $past(set_vec))); // R10
    AST_FLAG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((otg_stat & ~clr_mask & irq_ie) == '0) && ((set_vec & irq_ie) == '0))
        |=> (!otg_irq || irq_ie != $past(irq_ie))); // R11
endmodule

// File: rtl/otg_pwr_wake.sv
module otg_pwr_wake
    import otg_pw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTER_CYC   = 4,
    parameter int STAB_CYC    = 16,
    parameter int N_EVT       = 9
) (
    input  logic             clk_aon,
    input  logic             rst_n,
    input  logic             in_session,
    input  logic             sleep_req,
    input  logic [2:0]       wake_en,
    input  logic             id_pin,
    input  logic             bsv_pin,
    input  logic             srp_det,
    input  logic             bus_cs,
    input  logic [N_EVT-1:0] evt_in,
    input  logic             clr_we,
    input  logic [N_EVT-1:0] clr_mask,
    input  logic [N_EVT-1:0] irq_ie,
    input  logic             otg_irq_en,
    input  logic             pin_en,
    output logic             osc_en,
    output logic             pll_en,
    output logic             cp_suspend,
    output logic             dc_suspend,
    output logic             hc_suspend,
    output logic             clk_valid,
    output logic [N_EVT-1:0] otg_stat,
    output logic             otg_irq,
    output logic             int_out
);
    logic [N_LINES-1:0] lines;
    logic [N_LINES-1:0] line_evt;
    logic [N_EVT-1:0]   set_vec;
    logic               wake;

    assign lines[LN_ID]  = id_pin;
    assign lines[LN_BSV] = bsv_pin;
    assign lines[LN_SRP] = srp_det;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        otg_line_sync #(
            .STAGES    (SYNC_STAGES),
            .RISE_ONLY (g == LN_SRP)
        ) u_sync (
            .clk     (clk_aon),
            .rst_n   (rst_n),
            .line_in (lines[g]),
            .evt     (line_evt[g])
        );
    end

    assign wake    = bus_cs | (|(line_evt & wake_en));
    assign set_vec = evt_in | {{(N_EVT-N_LINES){1'b0}}, line_evt};

    otg_ps_fsm #(
        .ENTER_CYC (ENTER_CYC),
        .STAB_CYC  (STAB_CYC)
    ) u_fsm (
        .clk        (clk_aon),
        .rst_n      (rst_n),
        .in_session (in_session),
        .sleep_req  (sleep_req),
        .wake       (wake),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .cp_suspend (cp_suspend),
        .dc_suspend (dc_suspend),
        .hc_suspend (hc_suspend),
        .clk_valid  (clk_valid)
    );

    otg_irq_cascade #(
        .N_EVT (N_EVT)
    ) u_irq (
        .clk        (clk_aon),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_we     (clr_we),
        .clr_mask   (clr_mask),
        .irq_ie     (irq_ie),
        .otg_irq_en (otg_irq_en),
        .pin_en     (pin_en),
        .otg_stat   (otg_stat),
        .otg_irq    (otg_irq),
        .int_out    (int_out)
    );

    AST_DISABLED_NO_WAKE: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (cp_suspend && !bus_cs && ((line_evt & wake_en) == '0)) |=> cp_suspend); // R6
    AST_CS_WAKE: assert property (@(posedge clk_aon) disable iff (!rst_n)
        (cp_suspend && bus_cs) |=> (osc_en && pll_en && !clk_valid)); // R7
endmodule

// File: tb/sim_otg_pwr_wake.sv
module sim_otg_pwr_wake;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_session = 1'b0, sleep_req = 1'b0, bus_cs = 1'b0;
    logic [2:0] wake_en = 3'b000;
    logic id_pin = 1'b0, bsv_pin = 1'b0, srp_det = 1'b0;
    logic [NE-1:0] evt_in = '0, clr_mask = '0, irq_ie = '0;
    logic clr_we = 1'b0, otg_irq_en = 1'b0, pin_en = 1'b0;
    logic osc_en, pll_en, cp_suspend, dc_suspend, hc_suspend, clk_valid;
    logic [NE-1:0] otg_stat;
    logic otg_irq, int_out;

    int n_chk = 0, n_fail = 0;
    logic [NE-1:0] m_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    otg_pwr_wake u0 (
        .clk_aon(clk), .rst_n(rst_n), .in_session(in_session), .sleep_req(sleep_req),
        .wake_en(wake_en), .id_pin(id_pin), .bsv_pin(bsv_pin), .srp_det(srp_det),
        .bus_cs(bus_cs), .evt_in(evt_in), .clr_we(clr_we), .clr_mask(clr_mask),
        .irq_ie(irq_ie), .otg_irq_en(otg_irq_en), .pin_en(pin_en),
        .osc_en(osc_en), .pll_en(pll_en), .cp_suspend(cp_suspend),
        .dc_suspend(dc_suspend), .hc_suspend(hc_suspend), .clk_valid(clk_valid),
        .otg_stat(otg_stat), .otg_irq(otg_irq), .int_out(int_out)
    );

    // power vector order: osc, pll, cp_suspend, dc_suspend, hc_suspend, clk_valid
    localparam logic [5:0] PW_ACT = 6'b110001;
    localparam logic [5:0] PW_ENT = 6'b110111;
    localparam logic [5:0] PW_SLP = 6'b001110;
    localparam logic [5:0] PW_WAK = 6'b110110;

    function automatic logic [5:0] pw();
        return {osc_en, pll_en, cp_suspend, dc_suspend, hc_suspend, clk_valid};
    endfunction

    function automatic logic [NE-1:0] next_stat(logic [NE-1:0] s, logic we,
                                                logic [NE-1:0] m, logic [NE-1:0] set);
        return (we ? (s & ~m) : s) | set;
    endfunction

    function automatic logic [1:0] exp_irq(logic [NE-1:0] s, logic [NE-1:0] ie,
                                           logic en, logic pe);
        logic f;
        f = |(s & ie);
        return {f, f & en & pe};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter_sleep();
        in_session = 1'b0;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        check("R2 entry window", pw(), PW_ENT);
        step(3);
        check("R2 entry window end", pw(), PW_ENT);
        step(1);
        check("R2 sleep", pw(), PW_SLP);
    endtask

    task automatic finish_wake(string req);
        check(req, pw(), PW_WAK);
        step(15);
        check("R8 still stabilizing", pw(), PW_WAK);
        step(1);
        check("R8 active after window", pw(), PW_ACT);
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_mask = '1;
        step(1);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R2 reset power state", pw(), PW_ACT);
        check("R10 reset status", otg_stat, '0);
        check("R11 reset irq", {otg_irq, int_out}, 2'b00);

        // R1: request during a session is ignored
        in_session = 1'b1; sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        check("R1 in-session request ignored", pw(), PW_ACT);
        step(5);
        check("R1 still active", pw(), PW_ACT);

        // R7: chip select wakes regardless of enables
        wake_en = 3'b000;
        enter_sleep();
        bus_cs = 1'b1; step(1); bus_cs = 1'b0;
        finish_wake("R7 cs wake");

        // R3: ID change with enable
        wake_en = 3'b001;
        enter_sleep();
        id_pin = 1'b1;
        step(2);
        check("R3 not yet awake", pw(), PW_SLP);
        step(1);
        check("R10 id status bit0", otg_stat, 9'h001);
        finish_wake("R3 id wake");
        clear_all();

        // R6: B-session-valid change with only ID enabled stays asleep
        wake_en = 3'b001;
        enter_sleep();
        bsv_pin = 1'b1;
        step(8);
        check("R6 disabled bsv keeps sleep", pw(), PW_SLP);
        check("R10 bsv status bit1", otg_stat, 9'h002);
        bus_cs = 1'b1; step(1); bus_cs = 1'b0;
        finish_wake("R7 cs wake after disabled event");
        clear_all();

        // R4: B-session-valid change with enable
        wake_en = 3'b010;
        enter_sleep();
        bsv_pin = 1'b0;
        step(3);
        finish_wake("R4 bsv wake");
        clear_all();

        // R5: session-request rise with enable
        wake_en = 3'b100;
        enter_sleep();
        srp_det = 1'b1;
        step(3);
        check("R10 srp status bit2", otg_stat, 9'h004);
        srp_det = 1'b0;
        finish_wake("R5 srp wake");
        clear_all();

        // R9: wake during entry aborts
        wake_en = 3'b000;
        in_session = 1'b0; sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        step(1);
        check("R9 in entry", pw(), PW_ENT);
        bus_cs = 1'b1; step(1); bus_cs = 1'b0;
        check("R9 abort to active", pw(), PW_ACT);
        step(6);
        check("R9 stays active", pw(), PW_ACT);

        // R10/R11: random status and gating against the model
        clear_all();
        m_stat = '0;
        for (int i = 0; i < 400; i++) begin
            evt_in     = NE'($urandom) & NE'($urandom);
            clr_we     = 1'($urandom);
            clr_mask   = NE'($urandom);
            irq_ie     = NE'($urandom);
            otg_irq_en = 1'($urandom);
            pin_en     = 1'($urandom);
            if (i % 50 == 0) begin
                evt_in = 9'h1FF; clr_we = 1'b1; clr_mask = 9'h1FF;
            end
            m_stat = next_stat(m_stat, clr_we, clr_mask, evt_in);
            step(1);
            check("R10 status", otg_stat, m_stat);
            check("R11 irq cascade", {otg_irq, int_out},
                  exp_irq(m_stat, irq_ie, otg_irq_en, pin_en));
        end
        evt_in = '0; clr_we = 1'b1; clr_mask = '1; irq_ie = '1;
        otg_irq_en = 1'b1; pin_en = 1'b1;
        step(1);
        clr_we = 1'b0;
        check("R11 flag drops after full clear", {otg_irq, int_out}, 2'b00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule